// File: doc/BRIEF.md
# Receive Elastic Bit Buffer with Programmed Start Offset

This block is a bit-serial elastic store placed between a line-side receiver and a PCM-side serial transmitter. Payload bits enter one at a time when the line side marks them valid. The PCM side takes one bit per PCM bit strobe once its frame has started. Both sides share one clock. The line side qualifies its writes with a valid strobe, and the PCM side qualifies its reads with a bit-enable strobe.

A receiver-reset command empties the store, clears the error flags and captures the programmed water level. The block then waits for the next line frame start. It raises the PCM frame start a programmed number of clock cycles later, and this sets the initial fill. After that single alignment the offset between the two frames drifts freely: later line frame starts are ignored and nothing re-aligns the sides. A fill output shows how many bits are held. Two sticky flags report writes refused at the fill limit and reads attempted on an empty store.

Top module: `rx_elastic_fifo`

## Requirements
- R1: After `rst_n` low or a `rx_reset` pulse, `fill_level` is 0 and `overflow` and `underflow` are 0. After `rst_n` alone, `wr_valid` has no effect on `fill_level` until a `rx_reset` has been issued.
- R2: `water_level` is captured only in the cycle where `rx_reset` is high. Changing it afterwards does not alter the delay that is applied.
- R3: With captured level N, `pcm_start` is high for one cycle, exactly N cycles after the cycle in which `line_start` is high. For N = 0 it is high in that same cycle.
- R4: `pcm_start` fires at most once per `rx_reset`. Later `line_start` pulses produce no `pcm_start`.
- R5: A bit is written only when `wr_valid` is high and a line frame start has been seen since the last `rx_reset`. The line-start cycle itself accepts no write.
- R6: A bit is read only in a cycle with `pcm_bit_en` high that comes after the `pcm_start` cycle. Bits leave in the order they were written, and `rd_bit` shows each bit from the clock edge that ends its read cycle.
- R7: `fill_level` equals accepted writes minus successful reads. A cycle with both a write and a read leaves it unchanged. Writing every cycle of a delay of N gives an initial fill of N.
- R8: A write that finds `fill_level` at the limit is dropped and sets `overflow`. The limit is `fill_limit`, clamped to the storage depth.
- R9: A read with `fill_level` at 0 sets `underflow`, drives `rd_bit` to 0 and leaves `fill_level` at 0.
- R10: `overflow` and `underflow` stay high until `rst_n` or `rx_reset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_reset | input | 1 | Receiver-reset command: clears the store and captures the water level |
| water_level | input | 8 | Cycles from line frame start to PCM frame start |
| fill_limit | input | 8 | Largest number of bits that may be held |
| line_start | input | 1 | Line 6 ms frame start pulse |
| wr_valid | input | 1 | Payload bit valid on the line side |
| wr_bit | input | 1 | Payload bit |
| pcm_bit_en | input | 1 | PCM bit strobe |
| pcm_start | output | 1 | Pulse marking the aligned PCM frame start |
| rd_bit | output | 1 | Last bit read |
| fill_level | output | 8 | Number of bits held |
| overflow | output | 1 | Sticky: a write was refused at the limit |
| underflow | output | 1 | Sticky: a read was attempted on an empty store |

## Verification
The offset is tried with a nonzero level that is changed after capture, and with level zero. This separates a delay counted from the captured value from one counted from the live input, and also catches an off-by-one at the boundary. Writes are driven every cycle of the delay with an irregular bit pattern, so the fill at PCM start and the read-back order expose both count errors and pointer errors. A small fill limit, reads past empty, and simultaneous read and write show apart the dropped-write, empty-read and net-zero fill cases. A second line start after alignment checks that no re-alignment takes place.

// File: rtl/rx_efifo_pkg.sv
// Shared types for the receive elastic bit buffer.
package rx_efifo_pkg;
    // Alignment phase: idle after power reset, waiting for the line frame,
    // counting the programmed delay, or running.
    typedef enum logic [1:0] {
        PH_IDLE      = 2'd0,
        PH_WAIT_LINE = 2'd1,
        PH_DELAY     = 2'd2,
        PH_RUN       = 2'd3
    } phase_e;
endpackage

// File: rtl/rx_efifo_phase.sv
// Alignment controller. It captures the water level on clear, waits for a
// line frame start, counts the delay and pulses pcm_start once.
// Assumes: clr is a single-cycle command; line_start is a one-cycle pulse.
module rx_efifo_phase
    import rx_efifo_pkg::*;
#(
    parameter int WL_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            line_start,
    input  logic [WL_W-1:0] water_level,
    output logic            pcm_start,
    output logic            accept_wr,
    output logic            run
);
    phase_e          st, st_nx;
    logic [WL_W-1:0] wl_q;
    logic [WL_W-1:0] dly_cnt;

    // Next phase and start pulse.
    always_comb begin
        st_nx     = st;
        pcm_start = 1'b0;
        case (st)
            PH_WAIT_LINE: begin
                if (line_start) begin
                    if (wl_q == '0) begin
                        pcm_start = 1'b1;
                        st_nx     = PH_RUN;
                    end else begin
                        st_nx = PH_DELAY;
                    end
                end
            end
            PH_DELAY: begin
                if (dly_cnt == WL_W'(1)) begin
                    pcm_start = 1'b1;
                    st_nx     = PH_RUN;
                end
            end
            default: st_nx = st;
        endcase
        if (clr) pcm_start = 1'b0;
    end

    // Phase register, captured level and delay counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= PH_IDLE;
            wl_q    <= '0;
            dly_cnt <= '0;
        end else if (clr) begin
            st      <= PH_WAIT_LINE;
            wl_q    <= water_level;
            dly_cnt <= '0;
        end else begin
            st <= st_nx;
            if (st == PH_WAIT_LINE && line_start)
                dly_cnt <= wl_q;
            else if (st == PH_DELAY)
                dly_cnt <= dly_cnt - WL_W'(1);
        end
    end

    assign accept_wr = (st == PH_DELAY || st == PH_RUN) && !clr;
    assign run       = (st == PH_RUN) && !clr;

    // R4: once running, no further start pulse.
    p_start_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_RUN) |-> !pcm_start);

    // R3: the delay counter steps down by one each cycle until the start.
    p_delay_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_DELAY && !clr && dly_cnt != WL_W'(1)) |=>
        (st == PH_DELAY && dly_cnt == $past(dly_cnt) - WL_W'(1)));

    // R2: the captured level changes only on a clear command.
    p_wl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> $stable(wl_q));
endmodule

// File: rtl/rx_efifo_store.sv
// Circular bit store with fill count. It refuses writes at the clamped limit
// and refuses reads when empty, and reports both events.
// Assumes: wr_en and rd_en are already qualified by the alignment phase.
module rx_efifo_store #(
    parameter int DEPTH = 185,
    parameter int CNT_W = 8,
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic             wr_bit,
    input  logic             rd_en,
    input  logic [CNT_W-1:0] limit,
    output logic             rd_bit,
    output logic [CNT_W-1:0] fill,
    output logic             wr_drop,
    output logic             rd_empty
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_P  = PTR_W'(DEPTH - 1);

    logic [DEPTH-1:0] mem;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] eff_lim;
    logic             do_wr, do_rd;

    // Clamp the programmed limit to the physical depth.
    always_comb eff_lim = (limit > DEPTH_C) ? DEPTH_C : limit;

    assign wr_drop  = wr_en && (fill >= eff_lim);
    assign rd_empty = rd_en && (fill == '0);
    assign do_wr    = wr_en && !wr_drop;
    assign do_rd    = rd_en && !rd_empty;

    // Bit storage; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_bit;
    end

    // Pointers, fill count and output bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
            rd_bit <= 1'b0;
        end else begin
            if (do_wr) wr_ptr <= (wr_ptr == LAST_P) ? '0 : wr_ptr + PTR_W'(1);
            if (do_rd) rd_ptr <= (rd_ptr == LAST_P) ? '0 : rd_ptr + PTR_W'(1);
            case ({do_wr, do_rd})
                2'b10:   fill <= fill + CNT_W'(1);
                2'b01:   fill <= fill - CNT_W'(1);
                default: fill <= fill;
            endcase
            if (do_rd)         rd_bit <= mem[rd_ptr];
            else if (rd_empty) rd_bit <= 1'b0;
        end
    end

    // R8: never more bits than the storage holds.
    p_fill_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= DEPTH_C);

    // R7: the fill moves by at most one bit per cycle.
    p_fill_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (fill == $past(fill) || fill == $past(fill) + 1'b1 ||
                  fill + 1'b1 == $past(fill)));

    // R8: a refused write with no read leaves the fill alone.
    p_drop_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_drop && !rd_en && !clr) |=> (fill == $past(fill)));
endmodule

// File: rtl/rx_efifo_flags.sv
// Sticky error flags for refused writes and empty reads.
// Assumes: events are single-cycle qualified strobes from the store.
module rx_efifo_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ovf_evt,
    input  logic udf_evt,
    output logic overflow,
    output logic underflow
);
    // Set on event, clear only on reset or clear command.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            if (ovf_evt) overflow  <= 1'b1;
            if (udf_evt) underflow <= 1'b1;
        end
    end

    // R10: flags persist until cleared.
    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !clr) |=> overflow);
    p_udf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !clr) |=> underflow);
endmodule

// File: rtl/rx_elastic_fifo.sv
// Receive elastic bit buffer top. It ties the alignment controller, the bit
// store and the error flags together.
// Assumes: one shared clock; writes and reads are qualified by strobes.
module rx_elastic_fifo #(
    parameter int DEPTH = 185,
    parameter int WL_W  = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_reset,
    input  logic [WL_W-1:0]  water_level,
    input  logic [CNT_W-1:0] fill_limit,
    input  logic             line_start,
    input  logic             wr_valid,
    input  logic             wr_bit,
    input  logic             pcm_bit_en,
    output logic             pcm_start,
    output logic             rd_bit,
    output logic [CNT_W-1:0] fill_level,
    output logic             overflow,
    output logic             underflow
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic accept_wr, run, wr_drop, rd_empty;

    rx_efifo_phase #(.WL_W(WL_W)) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (rx_reset),
        .line_start  (line_start),
        .water_level (water_level),
        .pcm_start   (pcm_start),
        .accept_wr   (accept_wr),
        .run         (run)
    );

    rx_efifo_store #(.DEPTH(DEPTH), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (rx_reset),
        .wr_en    (wr_valid && accept_wr),
        .wr_bit   (wr_bit),
        .rd_en    (pcm_bit_en && run),
        .limit    (fill_limit),
        .rd_bit   (rd_bit),
        .fill     (fill_level),
        .wr_drop  (wr_drop),
        .rd_empty (rd_empty)
    );

    rx_efifo_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (rx_reset),
        .ovf_evt   (wr_drop),
        .udf_evt   (rd_empty),
        .overflow  (overflow),
        .underflow (underflow)
    );

    // R9: underflow rises only after a PCM bit strobe.
    p_udf_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underflow) |-> $past(pcm_bit_en));

    // R8: overflow rises only after a valid write attempt.
    p_ovf_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(wr_valid));
endmodule

// File: tb/rx_elastic_fifo_tb.sv
// Directed bench for the receive elastic bit buffer.
module rx_elastic_fifo_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_reset = 1'b0;
    logic [7:0] water_level = '0;
    logic [7:0] fill_limit = 8'd185;
    logic       line_start = 1'b0;
    logic       wr_valid = 1'b0;
    logic       wr_bit = 1'b0;
    logic       pcm_bit_en = 1'b0;
    logic       pcm_start, rd_bit, overflow, underflow;
    logic [7:0] fill_level;
    logic       saw_start;
    int         total = 0;
    int         bad = 0;

    always #5 clk = ~clk;

    rx_elastic_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .rx_reset(rx_reset),
        .water_level(water_level), .fill_limit(fill_limit),
        .line_start(line_start), .wr_valid(wr_valid), .wr_bit(wr_bit),
        .pcm_bit_en(pcm_bit_en), .pcm_start(pcm_start), .rd_bit(rd_bit),
        .fill_level(fill_level), .overflow(overflow), .underflow(underflow)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, note pcm_start, wait past the rise.
    task automatic tick(input logic rr, input logic ls, input logic wv,
                        input logic wb, input logic be);
        @(negedge clk);
        rx_reset = rr; line_start = ls; wr_valid = wv; wr_bit = wb; pcm_bit_en = be;
        #1 saw_start = pcm_start;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        tick(0, 0, 0, 0, 0);
        tick(0, 0, 0, 0, 0);
        rst_n = 1'b1;
        chk("R1 fill after reset", fill_level, 0);
        chk("R1 overflow after reset", overflow, 0);
        chk("R1 underflow after reset", underflow, 0);
        tick(0, 1, 1, 1, 0);
        tick(0, 0, 1, 1, 0);
        chk("R1 writes ignored before rx_reset", fill_level, 0);
    endtask

    task automatic t_delay_and_order();
        logic [7:0] pat = 8'b1011_0010;
        int start_idx = -1;
        int starts = 0;
        water_level = 8'd5;
        tick(1, 0, 0, 0, 0);
        water_level = 8'd2;                      // R2: must not take effect
        tick(0, 0, 1, 1, 0);
        tick(0, 0, 1, 0, 0);
        chk("R5 writes ignored before line start", fill_level, 0);
        tick(0, 1, 1, 1, 0);
        chk("R5 line start cycle writes nothing", fill_level, 0);
        for (int k = 1; k <= 12 && start_idx < 0; k++) begin
            tick(0, 0, 1, pat[k-1], 0);
            if (saw_start) start_idx = k;
        end
        chk("R2 R3 delay counted from captured level", start_idx, 5);
        chk("R7 initial fill equals delay", fill_level, 5);
        for (int k = 0; k < 5; k++) begin
            tick(0, 0, 0, 0, 1);
            chk("R6 read order", rd_bit, pat[k]);
        end
        chk("R7 fill after draining", fill_level, 0);
        tick(0, 1, 0, 0, 0);
        if (saw_start) starts++;
        for (int k = 0; k < 8; k++) begin
            tick(0, 0, 0, 0, 0);
            if (saw_start) starts++;
        end
        chk("R4 no re-alignment", starts, 0);
        tick(0, 0, 0, 0, 1);
        chk("R9 underflow set", underflow, 1);
        chk("R9 rd_bit zero on empty read", rd_bit, 0);
        chk("R9 fill stays zero", fill_level, 0);
        chk("R8 no overflow yet", overflow, 0);
    endtask

    task automatic t_zero_level();
        water_level = 8'd0;
        tick(1, 0, 0, 0, 0);
        chk("R1 underflow cleared by rx_reset", underflow, 0);
        tick(0, 1, 0, 0, 0);
        chk("R3 level zero starts same cycle", saw_start, 1);
        tick(0, 0, 1, 0, 0);
        tick(0, 0, 1, 1, 0);
        tick(0, 0, 1, 1, 0);
        chk("R7 three writes", fill_level, 3);
        tick(0, 0, 1, 0, 1);
        chk("R7 write plus read keeps fill", fill_level, 3);
        chk("R6 first bit out", rd_bit, 0);
        tick(0, 0, 0, 0, 1);
        chk("R6 second bit out", rd_bit, 1);
    endtask

    task automatic t_overflow();
        water_level = 8'd3;
        fill_limit  = 8'd2;
        tick(1, 0, 0, 0, 0);
        chk("R1 fill cleared by rx_reset", fill_level, 0);
        tick(0, 1, 0, 0, 0);
        tick(0, 0, 1, 1, 0);
        tick(0, 0, 1, 0, 0);
        tick(0, 0, 1, 1, 0);
        chk("R8 fill held at limit", fill_level, 2);
        chk("R8 overflow set", overflow, 1);
        tick(0, 0, 0, 0, 1);
        chk("R8 first kept bit", rd_bit, 1);
        tick(0, 0, 0, 0, 1);
        chk("R8 second kept bit", rd_bit, 0);
        for (int k = 0; k < 4; k++) tick(0, 0, 0, 0, 0);
        chk("R10 overflow sticky", overflow, 1);
        tick(1, 0, 0, 0, 0);
        chk("R10 overflow cleared by rx_reset", overflow, 0);
        fill_limit = 8'd185;
    endtask

    initial begin
        #1_000_000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_delay_and_order();
        t_zero_level();
        t_overflow();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule